// File: doc/BRIEF.md
# RV64I Instruction Decoder

This block turns one 32-bit base-integer instruction word of the 64-bit RISC-V architecture into control fields for an execution stage. It has no state. The output follows the input in the same cycle.

It sorts the word into an instruction class and an operation code within that class. It also returns the three register indices and the immediate, assembled and extended to `XLEN` bits. Every encoding outside the supported set drives `illegal` high and `valid` low. The compressed set, control-register access and the extensions are all treated as illegal.

The block sits between fetch and issue. A front end latches `inst` and uses `valid`, `dec_class`, `dec_op` and `imm` directly. A front end traps when `illegal` is high.

Top module: `rv64i_decode`

## Requirements
- R1: The 7-bit opcode `inst[6:0]` selects the class, encoded on `dec_class` as follows: 1 = upper immediate (0110111, 0010111), 2 = jump (1101111, 1100111), 3 = branch (1100011), 4 = load (0000011), 5 = store (0100011), 6 = immediate ALU (0010011, non-shift), 7 = immediate shift (0010011), 8 = register ALU (0110011), 9 = word immediate (0011011), 10 = word register (0111011), 11 = fence (0001111), 12 = system (1110011). `valid` is high exactly when the class is nonzero, and `illegal` is always its complement. Any other opcode is illegal, and that includes any opcode whose low two bits are not 11.
- R2: `rd`, `rs1` and `rs2` always show `inst[11:7]`, `inst[19:15]` and `inst[24:20]`, whether the word is legal or not.
- R3: Upper-immediate class: `dec_op` is 0 for opcode 0110111 and 1 for 0010111. `imm` is `inst[31:12]` followed by twelve zero bits, sign-extended from bit 31.
- R4: Jump class: opcode 1101111 gives `dec_op` 0 with `imm` = sext({inst[31], inst[19:12], inst[20], inst[30:21], 0}). Opcode 1100111 is legal only with funct3 `inst[14:12]` = 000. It gives `dec_op` 1 with `imm` = sext(inst[31:20]).
- R5: Branch class: `dec_op` = {0, funct3}. Funct3 values 010 and 011 are illegal. `imm` = sext({inst[31], inst[7], inst[30:25], inst[11:8], 0}).
- R6: Load class: `dec_op` = {0, funct3} for funct3 000 to 110, and funct3 111 is illegal. `imm` = sext(inst[31:20]).
- R7: Store class: funct3 000 to 011 are legal with `dec_op` = {0, funct3}, and funct3 1xx is illegal. `imm` = sext({inst[31:25], inst[11:7]}).
- R8: Opcode 0010011 with funct3 other than 001 and 101 gives class 6, `dec_op` = {0, funct3} and `imm` = sext(inst[31:20]).
- R9: Opcode 0010011 with funct3 001 requires `inst[31:26]` = 000000 and gives `dec_op` 0001. With funct3 101 it gives `dec_op` 0101 for 000000 and 1101 for 010000. Any other `inst[31:26]` is illegal. `imm` is the zero-extended 6-bit `inst[25:20]`.
- R10: Register ALU class: funct7 `inst[31:25]` = 0000000 gives `dec_op` = {0, funct3} for any funct3. Funct7 0100000 is legal only with funct3 000 or 101, and gives `dec_op` = {1, funct3}. Every other funct7 is illegal. `imm` is 0.
- R11: Word classes. Opcode 0011011 accepts funct3 000 (any upper bits, `dec_op` 0, `imm` = sext(inst[31:20])). It accepts funct3 001 with funct7 0000000 (`dec_op` 1), and funct3 101 with funct7 0000000 or 0100000 (`dec_op` 5 or 13). For those shifts `imm` is the zero-extended 5-bit `inst[24:20]`. Opcode 0111011 accepts funct3 000 and 101 with funct7 0000000 or 0100000, and funct3 001 with funct7 0000000, with `dec_op` = {funct7[5], funct3} and `imm` 0.
- R12: Fence class: `dec_op` 0 requires `inst[31:28]`, `rs1`, funct3 and `rd` all zero. `dec_op` 1 requires `inst[31:15]` = 0, funct3 = 001 and `rd` = 0. System class accepts only 0x00000073 (`dec_op` 0) and 0x00100073 (`dec_op` 1). Both classes give `imm` 0.
- R13: Whenever `illegal` is high, `dec_class`, `dec_op` and `imm` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| inst | input | 32 | Instruction word to decode |
| valid | output | 1 | Word matches a supported encoding |
| illegal | output | 1 | Word matches no supported encoding |
| dec_class | output | 4 | Instruction class code (R1) |
| dec_op | output | 4 | Operation within the class |
| rs1 | output | 5 | First source register index |
| rs2 | output | 5 | Second source register index |
| rd | output | 5 | Destination register index |
| imm | output | XLEN | Assembled, extended immediate |

## Verification
The checker's rules are evaluated only while every bit of `inst` is known. A word containing X or Z bits is never checked. The bench drives fully known words from its first cycle, so every rule is active throughout the run. The sweep sets every opcode against every funct3 and a spread of funct7 values, including both shift bit-25 states. Each of those combinations is paired with three register-field patterns, one of them all-zero so that the exact fence and system words are reached. Offset encoders in the bench then build branch, jump, upper and store words from chosen signed offsets. Those tests confirm that the scattered immediate bits come back in the right order.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;

    localparam int unsigned REG_IDX_W = 5;
    localparam int unsigned OP_W      = 4;

    localparam logic [6:0] OPC_LUI    = 7'b0110111;
    localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [6:0] OPC_OP     = 7'b0110011;
    localparam logic [6:0] OPC_OPIMMW = 7'b0011011;
    localparam logic [6:0] OPC_OPW    = 7'b0111011;
    localparam logic [6:0] OPC_FENCE  = 7'b0001111;
    localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

    localparam logic [6:0] F7_BASE = 7'b0000000;
    localparam logic [6:0] F7_ALT  = 7'b0100000;

    typedef enum logic [3:0] {
        CL_NONE   = 4'd0,
        CL_UPPER  = 4'd1,
        CL_JUMP   = 4'd2,
        CL_BRANCH = 4'd3,
        CL_LOAD   = 4'd4,
        CL_STORE  = 4'd5,
        CL_ALUI   = 4'd6,
        CL_SHIFTI = 4'd7,
        CL_ALUR   = 4'd8,
        CL_WORDI  = 4'd9,
        CL_WORDR  = 4'd10,
        CL_FENCE  = 4'd11,
        CL_SYSTEM = 4'd12
    } dec_class_e;

    typedef enum logic [2:0] {
        FM_NONE = 3'd0,
        FM_I    = 3'd1,
        FM_S    = 3'd2,
        FM_B    = 3'd3,
        FM_U    = 3'd4,
        FM_J    = 3'd5,
        FM_SH6  = 3'd6,
        FM_SH5  = 3'd7
    } imm_fmt_e;

    typedef struct packed {
        logic             legal;
        dec_class_e       cls;
        logic [OP_W-1:0]  op;
        imm_fmt_e         fmt;
    } dec_ctl_t;

    typedef struct packed {
        logic                  valid;
        logic                  illegal;
        dec_class_e            cls;
        logic [OP_W-1:0]       op;
        logic [REG_IDX_W-1:0]  rs1;
        logic [REG_IDX_W-1:0]  rs2;
        logic [REG_IDX_W-1:0]  rd;
    } dec_out_t;

endpackage

// File: rtl/rvdec_ctl.sv
module rvdec_ctl
    import rvdec_pkg::*;
(
    input  logic [31:0] inst,
    output dec_ctl_t    ctl
);

    function automatic dec_ctl_t mk(input dec_class_e c,
                                    input logic [OP_W-1:0] o,
                                    input imm_fmt_e f);
        dec_ctl_t r;
        r.legal = 1'b1;
        r.cls   = c;
        r.op    = o;
        r.fmt   = f;
        return r;
    endfunction

    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;
    logic [5:0] f6;
    dec_ctl_t   ctl_d;

    assign opc = inst[6:0];
    assign f3  = inst[14:12];
    assign f7  = inst[31:25];
    assign f6  = inst[31:26];

    always_comb begin
        ctl_d = '{legal: 1'b0, cls: CL_NONE, op: '0, fmt: FM_NONE};
        case (opc)
            OPC_LUI:   ctl_d = mk(CL_UPPER, 4'd0, FM_U);
            OPC_AUIPC: ctl_d = mk(CL_UPPER, 4'd1, FM_U);
            OPC_JAL:   ctl_d = mk(CL_JUMP,  4'd0, FM_J);
            OPC_JALR: begin
                if (f3 == 3'b000) ctl_d = mk(CL_JUMP, 4'd1, FM_I);
            end
            OPC_BRANCH: begin
                if (f3[2:1] != 2'b01) ctl_d = mk(CL_BRANCH, {1'b0, f3}, FM_B);
            end
            OPC_LOAD: begin
                if (f3 != 3'b111) ctl_d = mk(CL_LOAD, {1'b0, f3}, FM_I);
            end
            OPC_STORE: begin
                if (!f3[2]) ctl_d = mk(CL_STORE, {1'b0, f3}, FM_S);
            end
            OPC_OPIMM: begin
                case (f3)
                    3'b001: begin
                        if (f6 == 6'b000000) ctl_d = mk(CL_SHIFTI, 4'b0001, FM_SH6);
                    end
                    3'b101: begin
                        if (f6 == 6'b000000)
                            ctl_d = mk(CL_SHIFTI, 4'b0101, FM_SH6);
                        else if (f6 == 6'b010000)
                            ctl_d = mk(CL_SHIFTI, 4'b1101, FM_SH6);
                    end
                    default: ctl_d = mk(CL_ALUI, {1'b0, f3}, FM_I);
                endcase
            end
            OPC_OP: begin
                if (f7 == F7_BASE)
                    ctl_d = mk(CL_ALUR, {1'b0, f3}, FM_NONE);
                else if (f7 == F7_ALT && (f3 == 3'b000 || f3 == 3'b101))
                    ctl_d = mk(CL_ALUR, {1'b1, f3}, FM_NONE);
            end
            OPC_OPIMMW: begin
                case (f3)
                    3'b000: ctl_d = mk(CL_WORDI, 4'd0, FM_I);
                    3'b001: begin
                        if (f7 == F7_BASE) ctl_d = mk(CL_WORDI, 4'b0001, FM_SH5);
                    end
                    3'b101: begin
                        if (f7 == F7_BASE)
                            ctl_d = mk(CL_WORDI, 4'b0101, FM_SH5);
                        else if (f7 == F7_ALT)
                            ctl_d = mk(CL_WORDI, 4'b1101, FM_SH5);
                    end
                    default: ;
                endcase
            end
            OPC_OPW: begin
                case (f3)
                    3'b000, 3'b101: begin
                        if (f7 == F7_BASE)
                            ctl_d = mk(CL_WORDR, {1'b0, f3}, FM_NONE);
                        else if (f7 == F7_ALT)
                            ctl_d = mk(CL_WORDR, {1'b1, f3}, FM_NONE);
                    end
                    3'b001: begin
                        if (f7 == F7_BASE) ctl_d = mk(CL_WORDR, 4'b0001, FM_NONE);
                    end
                    default: ;
                endcase
            end
            OPC_FENCE: begin
                if (inst[31:28] == 4'b0 && inst[19:15] == 5'b0 &&
                    inst[11:7] == 5'b0 && f3 == 3'b000)
                    ctl_d = mk(CL_FENCE, 4'd0, FM_NONE);
                else if (inst[31:15] == 17'b0 && inst[11:7] == 5'b0 && f3 == 3'b001)
                    ctl_d = mk(CL_FENCE, 4'd1, FM_NONE);
            end
            OPC_SYSTEM: begin
                if (inst == 32'h0000_0073)
                    ctl_d = mk(CL_SYSTEM, 4'd0, FM_NONE);
                else if (inst == 32'h0010_0073)
                    ctl_d = mk(CL_SYSTEM, 4'd1, FM_NONE);
            end
            default: ;
        endcase
    end

    assign ctl = ctl_d;

endmodule

// File: rtl/rvdec_imm.sv
module rvdec_imm
    import rvdec_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [31:7]     inst_hi,
    input  imm_fmt_e        fmt,
    output logic [XLEN-1:0] imm
);

    localparam int unsigned EXT_I  = XLEN - 12;
    localparam int unsigned EXT_B  = XLEN - 13;
    localparam int unsigned EXT_U  = XLEN - 32;
    localparam int unsigned EXT_J  = XLEN - 21;
    localparam int unsigned PAD_S6 = XLEN - 6;
    localparam int unsigned PAD_S5 = XLEN - 5;

    logic            sgn;
    logic [XLEN-1:0] imm_d;

    assign sgn = inst_hi[31];

    always_comb begin
        case (fmt)
            FM_I:   imm_d = {{EXT_I{sgn}}, inst_hi[31:20]};
            FM_S:   imm_d = {{EXT_I{sgn}}, inst_hi[31:25], inst_hi[11:7]};
            FM_B:   imm_d = {{EXT_B{sgn}}, sgn, inst_hi[7], inst_hi[30:25],
                             inst_hi[11:8], 1'b0};
            FM_U:   imm_d = {{EXT_U{sgn}}, inst_hi[31:12], 12'b0};
            FM_J:   imm_d = {{EXT_J{sgn}}, sgn, inst_hi[19:12], inst_hi[20],
                             inst_hi[30:21], 1'b0};
            FM_SH6: imm_d = {{PAD_S6{1'b0}}, inst_hi[25:20]};
            FM_SH5: imm_d = {{PAD_S5{1'b0}}, inst_hi[24:20]};
            default: imm_d = '0;
        endcase
    end

    assign imm = imm_d;

endmodule

// File: rtl/rv64i_decode.sv
module rv64i_decode
    import rvdec_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [31:0]     inst,
    output logic            valid,
    output logic            illegal,
    output logic [3:0]      dec_class,
    output logic [3:0]      dec_op,
    output logic [4:0]      rs1,
    output logic [4:0]      rs2,
    output logic [4:0]      rd,
    output logic [XLEN-1:0] imm
);

    dec_ctl_t        ctl;
    logic [XLEN-1:0] imm_raw;
    dec_out_t        out_d;
    logic [XLEN-1:0] imm_d;

    rvdec_ctl i_ctl (
        .inst (inst),
        .ctl  (ctl)
    );

    rvdec_imm #(.XLEN(XLEN)) i_imm (
        .inst_hi (inst[31:7]),
        .fmt     (ctl.fmt),
        .imm     (imm_raw)
    );

    always_comb begin
        out_d.rs1     = inst[19:15];
        out_d.rs2     = inst[24:20];
        out_d.rd      = inst[11:7];
        out_d.valid   = ctl.legal;
        out_d.illegal = !ctl.legal;
        if (ctl.legal) begin
            out_d.cls = ctl.cls;
            out_d.op  = ctl.op;
            imm_d     = imm_raw;
        end else begin
            out_d.cls = CL_NONE;
            out_d.op  = '0;
            imm_d     = '0;
        end
    end

    assign valid     = out_d.valid;
    assign illegal   = out_d.illegal;
    assign dec_class = out_d.cls;
    assign dec_op    = out_d.op;
    assign rs1       = out_d.rs1;
    assign rs2       = out_d.rs2;
    assign rd        = out_d.rd;
    assign imm       = imm_d;

endmodule

// File: rtl/rv64i_decode_chk.sv
module rv64i_decode_chk #(
    parameter int unsigned XLEN = 64
) (
    input logic [31:0]     inst,
    input logic            valid,
    input logic            illegal,
    input logic [3:0]      dec_class,
    input logic [3:0]      dec_op,
    input logic [XLEN-1:0] imm
);

    always_comb begin
        if (!$isunknown(inst)) begin
            // R1: the class code and the valid flag agree
            a_r1_class_tracks_valid: assert (valid == (dec_class != 4'd0))
                else $error("class %0d with valid %0b", dec_class, valid);
            // R13: a rejected word carries no class, op or immediate
            a_r13_illegal_clean: assert (!illegal || (dec_op == 4'd0 && imm == '0))
                else $error("illegal word with op %0d imm %h", dec_op, imm);
            // R3: upper immediate keeps its low twelve bits clear
            a_r3_upper_low_zero: assert (dec_class != 4'd1 || imm[11:0] == 12'd0)
                else $error("upper immediate low bits %h", imm[11:0]);
            // R4: jump-and-link offsets are even
            a_r4_jal_even: assert (!(dec_class == 4'd2 && dec_op == 4'd0) || !imm[0])
                else $error("odd jump offset");
            // R5: branch offsets are even and funct3 01x never passes
            a_r5_branch_shape: assert (dec_class != 4'd3 || (!imm[0] && dec_op[2:1] != 2'b01))
                else $error("bad branch op %0d imm %h", dec_op, imm);
            // R6: no load with funct3 111
            a_r6_load_op: assert (dec_class != 4'd4 || dec_op != 4'd7)
                else $error("load op 7 accepted");
            // R7: store width within byte..double
            a_r7_store_width: assert (dec_class != 4'd5 || dec_op < 4'd4)
                else $error("store op %0d", dec_op);
            // R9: 64-bit shift amount stays below 64
            a_r9_shamt_range: assert (dec_class != 4'd7 || imm < 64)
                else $error("shift amount %0d", imm);
            // R11: word shift amount stays below 32
            a_r11_word_shamt: assert (!(dec_class == 4'd9 && dec_op != 4'd0) || imm < 32)
                else $error("word shift amount %0d", imm);
            // R12: system words are exact
            a_r12_system_exact: assert (dec_class != 4'd12 ||
                                        (inst[31:21] == 11'd0 && inst[19:7] == 13'd0))
                else $error("loose system word %h", inst);
        end
    end

endmodule

bind rv64i_decode rv64i_decode_chk #(.XLEN(XLEN)) i_chk (.*);

// File: tb/test_rv64i_decode.sv
`timescale 1ns/1ps
module test_rv64i_decode;

    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic [31:0]     inst;
    logic            valid, illegal;
    logic [3:0]      dec_class, dec_op;
    logic [4:0]      rs1, rs2, rd;
    logic [XLEN-1:0] imm;

    int  checks   = 0;
    int  failures = 0;
    bit  done     = 0;

    always #2 clk = ~clk;

    rv64i_decode #(.XLEN(XLEN)) i_rv64i_decode (
        .inst(inst), .valid(valid), .illegal(illegal),
        .dec_class(dec_class), .dec_op(dec_op),
        .rs1(rs1), .rs2(rs2), .rd(rd), .imm(imm)
    );

    function automatic logic [63:0] sx(input logic [63:0] v, input int bits);
        logic [63:0] r = v;
        for (int k = bits; k < 64; k++) r[k] = v[bits-1];
        return r;
    endfunction

    // Expected decode from the requirement text
    function automatic void expect_dec(input logic [31:0] w, output logic ok,
                                       output logic [3:0] c, output logic [3:0] o,
                                       output logic [63:0] im, output string tag);
        logic [6:0] opc = w[6:0];
        logic [2:0] f3  = w[14:12];
        logic [6:0] f7  = w[31:25];
        logic [63:0] iimm = sx({52'd0, w[31:20]}, 12);
        ok = 0; c = 0; o = 0; im = 0; tag = "R13";
        case (opc)
            7'b0110111: begin ok = 1; c = 1; o = 0; im = sx({32'd0, w[31:12], 12'd0}, 32); tag = "R3"; end
            7'b0010111: begin ok = 1; c = 1; o = 1; im = sx({32'd0, w[31:12], 12'd0}, 32); tag = "R3"; end
            7'b1101111: begin ok = 1; c = 2; o = 0; tag = "R4";
                im = sx({43'd0, w[31], w[19:12], w[20], w[30:21], 1'b0}, 21); end
            7'b1100111: begin tag = "R4"; if (f3 == 0) begin ok = 1; c = 2; o = 1; im = iimm; end end
            7'b1100011: begin tag = "R5";
                if (f3 != 2 && f3 != 3) begin ok = 1; c = 3; o = {1'b0, f3};
                    im = sx({51'd0, w[31], w[7], w[30:25], w[11:8], 1'b0}, 13); end end
            7'b0000011: begin tag = "R6"; if (f3 != 7) begin ok = 1; c = 4; o = {1'b0, f3}; im = iimm; end end
            7'b0100011: begin tag = "R7";
                if (f3 < 4) begin ok = 1; c = 5; o = {1'b0, f3}; im = sx({52'd0, w[31:25], w[11:7]}, 12); end end
            7'b0010011: begin
                if (f3 == 1 || f3 == 5) begin
                    tag = "R9";
                    if (w[31:26] == 0) begin ok = 1; c = 7; o = {1'b0, f3}; end
                    else if (f3 == 5 && w[31:26] == 6'b010000) begin ok = 1; c = 7; o = 4'd13; end
                    if (ok) im = {58'd0, w[25:20]};
                end else begin tag = "R8"; ok = 1; c = 6; o = {1'b0, f3}; im = iimm; end
            end
            7'b0110011: begin tag = "R10";
                if (f7 == 0) begin ok = 1; c = 8; o = {1'b0, f3}; end
                else if (f7 == 7'h20 && (f3 == 0 || f3 == 5)) begin ok = 1; c = 8; o = {1'b1, f3}; end
            end
            7'b0011011: begin tag = "R11";
                if (f3 == 0) begin ok = 1; c = 9; o = 0; im = iimm; end
                else if ((f3 == 1 && f7 == 0) || (f3 == 5 && (f7 == 0 || f7 == 7'h20))) begin
                    ok = 1; c = 9; o = {f7[5], f3}; im = {59'd0, w[24:20]}; end
            end
            7'b0111011: begin tag = "R11";
                if (((f3 == 0 || f3 == 5) && (f7 == 0 || f7 == 7'h20)) || (f3 == 1 && f7 == 0)) begin
                    ok = 1; c = 10; o = {f7[5], f3}; end
            end
            7'b0001111: begin tag = "R12";
                if (w[31:28] == 0 && w[19:15] == 0 && w[11:7] == 0 && f3 == 0) begin ok = 1; c = 11; o = 0; end
                else if (w[31:15] == 0 && w[11:7] == 0 && f3 == 1) begin ok = 1; c = 11; o = 1; end
            end
            7'b1110011: begin tag = "R12";
                if (w == 32'h73) begin ok = 1; c = 12; o = 0; end
                else if (w == 32'h0010_0073) begin ok = 1; c = 12; o = 1; end
            end
            default: tag = "R1";
        endcase
    endfunction

    task automatic apply_check(input logic [31:0] w);
        logic ok; logic [3:0] c, o; logic [63:0] im; string tag;
        @(posedge clk);
        inst = w;
        @(negedge clk);
        expect_dec(w, ok, c, o, im, tag);
        checks++;
        if (valid !== ok || illegal !== !ok || dec_class !== c || dec_op !== o || imm !== im) begin
            failures++;
            $display("FAIL %s inst=%h got v=%0b i=%0b c=%0d o=%0d imm=%h exp v=%0b c=%0d o=%0d imm=%h",
                     tag, w, valid, illegal, dec_class, dec_op, imm, ok, c, o, im);
        end
        checks++;
        if (rs1 !== w[19:15] || rs2 !== w[24:20] || rd !== w[11:7]) begin
            failures++;
            $display("FAIL R2 inst=%h got rs1=%0d rs2=%0d rd=%0d exp %0d %0d %0d",
                     w, rs1, rs2, rd, w[19:15], w[24:20], w[11:7]);
        end
    endtask

    task automatic imm_check(input string tag, input logic [31:0] w, input logic [63:0] exp_imm);
        @(posedge clk);
        inst = w;
        @(negedge clk);
        checks++;
        if (valid !== 1'b1 || imm !== exp_imm) begin
            failures++;
            $display("FAIL %s inst=%h got v=%0b imm=%h exp v=1 imm=%h", tag, w, valid, imm, exp_imm);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(4 * 190000);
        failures++;
        $display("FAIL watchdog expired after %0d checks, expected completion", checks);
        finish_run();
    end

    initial begin
        logic [6:0] f7_set [8] = '{7'h00, 7'h01, 7'h20, 7'h21, 7'h40, 7'h7f, 7'h08, 7'h60};
        logic [14:0] rf_set [3] = '{15'h0000, {5'h1f, 5'h0a, 5'h15}, {5'h01, 5'h00, 5'h00}};
        inst = 32'h0;
        // R13 / R1: all-zero word at the start is rejected
        @(negedge clk);
        checks++;
        if (valid !== 1'b0 || illegal !== 1'b1 || dec_class !== 4'd0 || imm !== '0) begin
            failures++;
            $display("FAIL R13 zero word got v=%0b i=%0b c=%0d imm=%h exp v=0 i=1 c=0 imm=0",
                     valid, illegal, dec_class, imm);
        end
        // R12 exact system and fence words
        apply_check(32'h0000_0073);
        apply_check(32'h0010_0073);
        apply_check(32'h0020_0073);
        apply_check(32'h0000_100F);
        apply_check(32'h0FF0_000F);
        apply_check(32'h1000_000F);
        // Sweep: R1, R5-R11, R13 over opcode x funct3 x funct7 x register fields
        for (int op = 0; op < 128; op++)
            for (int f3 = 0; f3 < 8; f3++)
                for (int k = 0; k < 8; k++)
                    for (int r = 0; r < 3; r++)
                        apply_check({f7_set[k], rf_set[r][14:5], f3[2:0], rf_set[r][4:0], op[6:0]});
        // R4: jump offsets built from the target distance
        for (int n = 0; n < 6; n++) begin
            logic signed [20:0] off;
            case (n)
                0: off = -21'sd2;  1: off = 21'sd2;  2: off = -21'sd1048576;
                3: off = 21'sd1048574; 4: off = 21'sh0AAAAA & ~21'sd1; default: off = 21'sh155554;
            endcase
            imm_check("R4", {off[20], off[10:1], off[11], off[19:12], 5'd1, 7'b1101111},
                      {{43{off[20]}}, off});
        end
        // R5: branch offsets
        for (int n = 0; n < 5; n++) begin
            logic signed [12:0] off;
            case (n)
                0: off = -13'sd4096; 1: off = 13'sd4094; 2: off = -13'sd2; 3: off = 13'sh0AAA; default: off = 13'sh1554;
            endcase
            imm_check("R5", {off[12], off[10:5], 5'd3, 5'd4, 3'b100, off[4:1], off[11], 7'b1100011},
                      {{51{off[12]}}, off});
        end
        // R7: store offsets
        imm_check("R7", {7'h7f, 5'd2, 5'd3, 3'b011, 5'h1f, 7'b0100011}, 64'hFFFF_FFFF_FFFF_FFFF);
        imm_check("R7", {7'h40, 5'd2, 5'd3, 3'b000, 5'h00, 7'b0100011}, 64'hFFFF_FFFF_FFFF_F800);
        // R3: upper immediate sign extension
        imm_check("R3", 32'h8000_0037, 64'hFFFF_FFFF_8000_0000);
        imm_check("R3", 32'h7FFF_F097, 64'h0000_0000_7FFF_F000);
        // R9: largest 64-bit shift amount
        imm_check("R9", {6'b010000, 6'd63, 5'd1, 3'b101, 5'd2, 7'b0010011}, 64'd63);
        finish_run();
    end

endmodule